// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Port

This block is the per-processor side of an interrupt controller. An upstream distributor offers it one candidate interrupt at a time, with its ID, its priority and, for software-generated interrupts, the number of the CPU that raised it. The port decides whether that candidate may reach its processor and drives a level interrupt request line when it may.

Software talks to the port through four word registers. The register select picks among them: 0 is control, 1 is priority mask, 2 is acknowledge, 3 is end-of-interrupt. A read of acknowledge returns the presented interrupt, marks it active and tells the distributor to drop its pending state. When nothing may be presented, the read returns the spurious ID 1023, which stops software's acknowledge loop. A write of an ID to end-of-interrupt ends servicing of that interrupt and lets it be presented again. An interrupt that is active is never presented a second time until its end-of-interrupt arrives.

Top module: `intc_cpu_port`

## Requirements
- R1: After reset the control and priority mask registers read 0, no interrupt is active, and the request line stays low whatever candidate is offered.
- R2: The request line is high exactly when control bit 0 is set, a candidate is valid, its ID is at most 510, its priority is below the mask, and that ID is not active. Candidates with IDs from 511 upward are never presented.
- R3: A read of acknowledge while the request line is high returns the candidate ID in bits [9:0], one cycle after the read. For IDs of 16 and above, all other bits are zero.
- R4: For candidate IDs 0 to 15, the acknowledge value also carries the source CPU number in bits [12:10].
- R5: A read of acknowledge while the request line is low returns 1023. It produces no take pulse and changes no active state.
- R6: A qualifying acknowledge makes that ID active. The same ID no longer raises the request line, while a different qualifying ID still does.
- R7: A write of an in-range active ID to end-of-interrupt clears its active state. It pulses the end-of-interrupt output with that ID, and the ID can be presented again.
- R8: A write to end-of-interrupt with an ID above 510 produces no pulse and leaves all active state unchanged. A write of an ID that is not active leaves other IDs' active state unchanged.
- R9: The priority test is strict: a priority equal to the mask value is masked. The lower the value, the more urgent the interrupt.
- R10: Control keeps only bit 0 and the priority mask keeps its low 8 bits. Both read back what was written.
- R11: A qualifying acknowledge read raises the take output in the same cycle, with the presented ID on the take ID output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 priority mask, 2 acknowledge, 3 end-of-interrupt |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| cand_valid_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| cand_src_i | input | 3 | Source CPU of a software-generated candidate |
| irq_o | output | 1 | Interrupt request to the processor |
| take_o | output | 1 | Acknowledge taken, distributor clears pending |
| take_id_o | output | 10 | ID taken on acknowledge |
| done_o | output | 1 | End-of-interrupt pulse to the distributor |
| done_id_o | output | 10 | ID ended |

## Verification
The bench builds the port with its default parameters: 10-bit IDs, a top valid ID of 510, 16 software-generated IDs, 8-bit priority and 3-bit source CPU numbers, with the source field enabled. With these values the test can reach the edges of the ID space directly. It offers the last valid ID 510 and the first invalid ID 511. It crosses the 15/16 boundary where the source field appears or vanishes. It writes an end-of-interrupt ID beyond the valid range. It also sets a priority exactly equal to the 0xF0 mask.

// File: rtl/intc_cpu_port_pkg.sv
package intc_cpu_port_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_PMASK = 2'd1,
      SEL_ACK   = 2'd2,
      SEL_EOI   = 2'd3
   } port_sel_e;

   localparam int SPURIOUS_ID = 1023;

endpackage

// File: rtl/intc_cpu_cfg.sv
module intc_cpu_cfg
   import intc_cpu_port_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PRIO_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [1:0]        sel_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              enable_o,
   output logic [PRIO_W-1:0] pmask_o
);

   if (PRIO_W > DATA_W) begin : g_bad_prio
      $error("intc_cpu_cfg: PRIO_W exceeds DATA_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_o <= 1'b0;
         pmask_o  <= '0;
      end else if (wr_i) begin
         if (sel_i == SEL_CTRL)  enable_o <= wdata_i[0];
         if (sel_i == SEL_PMASK) pmask_o  <= wdata_i[PRIO_W-1:0];
      end
   end

   // R10
   pmask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel_i == SEL_PMASK) |=> pmask_o == $past(wdata_i[PRIO_W-1:0]));

endmodule

// File: rtl/intc_cpu_active.sv
module intc_cpu_active #(
   parameter int ID_W   = 10,
   parameter int MAX_ID = 510
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_i,
   input  logic [ID_W-1:0] set_id_i,
   input  logic            clr_i,
   input  logic [ID_W-1:0] clr_id_i,
   input  logic [ID_W-1:0] query_id_i,
   output logic            query_active_o
);

   localparam int IDX_W = $clog2(MAX_ID + 1);
   localparam logic [ID_W-1:0] MAX_V = ID_W'(MAX_ID);

   if (IDX_W > ID_W) begin : g_bad_width
      $error("intc_cpu_active: MAX_ID does not fit ID_W");
   end

   logic [MAX_ID:0] act_q;
   logic [IDX_W-1:0] set_idx, clr_idx, qry_idx;

   assign set_idx = set_id_i[IDX_W-1:0];
   assign clr_idx = clr_id_i[IDX_W-1:0];
   assign qry_idx = query_id_i[IDX_W-1:0];

   for (genvar i = 0; i <= MAX_ID; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            act_q[i] <= 1'b0;
         else if (set_i && set_id_i == ID_W'(i))
            act_q[i] <= 1'b1;
         else if (clr_i && clr_id_i == ID_W'(i))
            act_q[i] <= 1'b0;
      end
   end

   assign query_active_o = (query_id_i <= MAX_V) ? act_q[qry_idx] : 1'b0;

   // R6
   set_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && set_id_i <= MAX_V) |=> act_q[$past(set_idx)]);

   // R7
   clear_unmarks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && clr_id_i <= MAX_V && !(set_i && set_id_i == clr_id_i))
      |=> !act_q[$past(clr_idx)]);

endmodule

// File: rtl/intc_cpu_select.sv
module intc_cpu_select #(
   parameter int ID_W   = 10,
   parameter int PRIO_W = 8,
   parameter int MAX_ID = 510
) (
   input  logic              enable_i,
   input  logic [PRIO_W-1:0] pmask_i,
   input  logic              cand_valid_i,
   input  logic [ID_W-1:0]   cand_id_i,
   input  logic [PRIO_W-1:0] cand_prio_i,
   input  logic              cand_active_i,
   output logic              present_o
);

   localparam logic [ID_W-1:0] MAX_V = ID_W'(MAX_ID);

   logic id_ok, prio_ok;

   assign id_ok     = cand_id_i <= MAX_V;
   assign prio_ok   = cand_prio_i < pmask_i;
   assign present_o = enable_i && cand_valid_i && id_ok && prio_ok && !cand_active_i;

endmodule

// File: rtl/intc_cpu_port.sv
module intc_cpu_port
   import intc_cpu_port_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int ID_W          = 10,
   parameter int PRIO_W        = 8,
   parameter int CPU_W         = 3,
   parameter int MAX_ID        = 510,
   parameter int SGI_COUNT     = 16,
   parameter bit SGI_SOURCE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_rd_i,
   input  logic              reg_wr_i,
   input  logic [1:0]        reg_sel_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              cand_valid_i,
   input  logic [ID_W-1:0]   cand_id_i,
   input  logic [PRIO_W-1:0] cand_prio_i,
   input  logic [CPU_W-1:0]  cand_src_i,
   output logic              irq_o,
   output logic              take_o,
   output logic [ID_W-1:0]   take_id_o,
   output logic              done_o,
   output logic [ID_W-1:0]   done_id_o
);

   localparam logic [ID_W-1:0] MAX_V  = ID_W'(MAX_ID);
   localparam logic [ID_W-1:0] SPUR_V = ID_W'(SPURIOUS_ID);
   localparam logic [ID_W-1:0] SGI_V  = ID_W'(SGI_COUNT);

   if (SPURIOUS_ID >= (1 << ID_W)) begin : g_bad_spur
      $error("intc_cpu_port: spurious ID does not fit ID_W");
   end
   if (MAX_ID >= SPURIOUS_ID || SGI_COUNT > MAX_ID) begin : g_bad_range
      $error("intc_cpu_port: ID ranges overlap");
   end
   if (ID_W + CPU_W > DATA_W) begin : g_bad_data
      $error("intc_cpu_port: ID and source fields exceed DATA_W");
   end

   logic              enable;
   logic [PRIO_W-1:0] pmask;
   logic              cand_active;
   logic              present;
   logic              ack_rd, eoi_wr;
   logic [ID_W-1:0]   eoi_id;
   logic [DATA_W-1:0] ack_word, rd_next;

   assign ack_rd = reg_rd_i && reg_sel_i == SEL_ACK;
   assign eoi_wr = reg_wr_i && reg_sel_i == SEL_EOI;
   assign eoi_id = reg_wdata_i[ID_W-1:0];

   intc_cpu_cfg #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (reg_wr_i),
      .sel_i    (reg_sel_i),
      .wdata_i  (reg_wdata_i),
      .enable_o (enable),
      .pmask_o  (pmask)
   );

   intc_cpu_select #(.ID_W(ID_W), .PRIO_W(PRIO_W), .MAX_ID(MAX_ID)) u_sel (
      .enable_i      (enable),
      .pmask_i       (pmask),
      .cand_valid_i  (cand_valid_i),
      .cand_id_i     (cand_id_i),
      .cand_prio_i   (cand_prio_i),
      .cand_active_i (cand_active),
      .present_o     (present)
   );

   intc_cpu_active #(.ID_W(ID_W), .MAX_ID(MAX_ID)) u_act (
      .clk            (clk),
      .rst_n          (rst_n),
      .set_i          (take_o),
      .set_id_i       (take_id_o),
      .clr_i          (done_o),
      .clr_id_i       (done_id_o),
      .query_id_i     (cand_id_i),
      .query_active_o (cand_active)
   );

   assign irq_o     = present;
   assign take_o    = ack_rd && present;
   assign take_id_o = cand_id_i;
   assign done_o    = eoi_wr && eoi_id <= MAX_V;
   assign done_id_o = eoi_id;

   if (SGI_SOURCE_EN) begin : g_src_field
      always_comb begin
         ack_word = '0;
         ack_word[ID_W-1:0] = cand_id_i;
         if (cand_id_i < SGI_V) ack_word[ID_W +: CPU_W] = cand_src_i;
      end
   end else begin : g_no_src_field
      always_comb begin
         ack_word = '0;
         ack_word[ID_W-1:0] = cand_id_i;
      end
   end

   always_comb begin
      rd_next = '0;
      unique case (reg_sel_i)
         SEL_CTRL:  rd_next[0] = enable;
         SEL_PMASK: rd_next[PRIO_W-1:0] = pmask;
         SEL_ACK:   if (present) rd_next = ack_word;
                    else rd_next[ID_W-1:0] = SPUR_V;
         default:   rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        reg_rdata_o <= '0;
      else if (reg_rd_i) reg_rdata_o <= rd_next;
   end

   // R3
   ack_returns_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> reg_rdata_o[ID_W-1:0] == $past(take_id_o));

   // R5
   ack_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !take_o) |=> reg_rdata_o[ID_W-1:0] == SPUR_V);

   // R6
   taken_not_again_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> !(irq_o && cand_id_i == $past(take_id_o)));

   // R8
   eoi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> done_id_o <= MAX_V);

endmodule

// File: tb/intc_cpu_port_test.sv
module intc_cpu_port_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_rd = 1'b0, reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cand_valid = 1'b0;
   logic [9:0]  cand_id = '0;
   logic [7:0]  cand_prio = '0;
   logic [2:0]  cand_src = '0;
   logic        irq, take, done;
   logic [9:0]  take_id, done_id;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   intc_cpu_port uut (
      .clk(clk), .rst_n(rst_n),
      .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .cand_valid_i(cand_valid), .cand_id_i(cand_id),
      .cand_prio_i(cand_prio), .cand_src_i(cand_src),
      .irq_o(irq), .take_o(take), .take_id_o(take_id),
      .done_o(done), .done_id_o(done_id)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic offer(input logic v, input int id, input int prio, input int src);
      @(negedge clk);
      cand_valid = v;
      cand_id    = 10'(id);
      cand_prio  = 8'(prio);
      cand_src   = 3'(src);
      #1;
   endtask

   task automatic wr(input int sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = 2'(sel); reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int sel, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_sel = 2'(sel);
      @(posedge clk); #1;
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   // acknowledge with checks on the take pulse in the read cycle
   task automatic ack(input string req, input logic exp_take, input int exp_id,
                      output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_sel = 2'd2;
      #1;
      chk({req, " take"}, {31'd0, take}, {31'd0, exp_take});
      if (exp_take) chk("R11 take id", {22'd0, take_id}, 32'(exp_id));
      @(posedge clk); #1;
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      offer(1'b1, 40, 0, 0);
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);
      rd(0, d); chk("R1 ctrl reset", d, 32'd0);
      rd(1, d); chk("R1 pmask reset", d, 32'd0);
   endtask

   task automatic t_config();
      logic [31:0] d;
      wr(0, 32'hFFFF_FFFF);
      rd(0, d); chk("R10 ctrl keeps bit0", d, 32'd1);
      wr(1, 32'h1234_56F0);
      rd(1, d); chk("R10 pmask readback", d, 32'h0000_00F0);
   endtask

   task automatic t_mask();
      offer(1'b1, 40, 8'hF0, 0);
      chk("R9 prio equal mask", {31'd0, irq}, 32'd0);
      offer(1'b1, 40, 8'hEF, 0);
      chk("R2 prio below mask", {31'd0, irq}, 32'd1);
      wr(0, 32'd0);
      chk("R2 disabled", {31'd0, irq}, 32'd0);
      wr(0, 32'd1);
      offer(1'b1, 511, 8'h00, 0);
      chk("R2 id 511 not presented", {31'd0, irq}, 32'd0);
      offer(1'b0, 40, 8'h00, 0);
      chk("R2 invalid candidate", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_ack_normal();
      logic [31:0] d;
      offer(1'b1, 510, 8'h10, 5);
      chk("R2 id 510 presented", {31'd0, irq}, 32'd1);
      ack("R11", 1'b1, 510, d);
      chk("R3 ack 510", d, 32'd510);
      chk("R6 same id masked", {31'd0, irq}, 32'd0);
      offer(1'b1, 33, 8'h10, 5);
      chk("R6 other id still signals", {31'd0, irq}, 32'd1);
      ack("R11", 1'b1, 33, d);
      chk("R3 ack 33", d, 32'd33);
   endtask

   task automatic t_spurious();
      logic [31:0] d;
      offer(1'b1, 510, 8'h10, 0);
      ack("R5 active", 1'b0, 0, d);
      chk("R5 spurious active", d, 32'd1023);
      offer(1'b0, 100, 8'h10, 0);
      ack("R5 idle", 1'b0, 0, d);
      chk("R5 spurious idle", d, 32'd1023);
      offer(1'b1, 511, 8'h10, 0);
      ack("R5 id 511", 1'b0, 0, d);
      chk("R5 spurious 511", d, 32'd1023);
      offer(1'b1, 100, 8'h10, 0);
      chk("R5 no state change", {31'd0, irq}, 32'd1);
   endtask

   task automatic t_eoi();
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 32'd700;
      #1;
      chk("R8 no pulse out of range", {31'd0, done}, 32'd0);
      @(posedge clk); #1;
      reg_wr = 1'b0;
      wr(3, 32'd200);
      offer(1'b1, 510, 8'h10, 0);
      chk("R8 510 still active", {31'd0, irq}, 32'd0);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 32'd510;
      #1;
      chk("R7 done pulse", {31'd0, done}, 32'd1);
      chk("R7 done id", {22'd0, done_id}, 32'd510);
      @(posedge clk); #1;
      reg_wr = 1'b0;
      chk("R7 510 presented again", {31'd0, irq}, 32'd1);
      offer(1'b1, 33, 8'h10, 0);
      chk("R8 33 still active", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_sgi();
      logic [31:0] d;
      offer(1'b1, 5, 8'h20, 6);
      ack("R4", 1'b1, 5, d);
      chk("R4 sgi source field", d, 32'h0000_1805);
      offer(1'b1, 15, 8'h20, 3);
      ack("R4", 1'b1, 15, d);
      chk("R4 id 15 source field", d, 32'h0000_0C0F);
      offer(1'b1, 16, 8'h20, 6);
      ack("R3", 1'b1, 16, d);
      chk("R3 id 16 no source", d, 32'd16);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_config();
      t_mask();
      t_ack_normal();
      t_spurious();
      t_eoi();
      t_sgi();
      repeat (2) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule